// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block runs the refill of a single cache line after a cacheable load misses. It takes the line address and the doubleword index that the load wants. It then issues the eight doubleword addresses of the line on the memory bus, starting with the wanted doubleword and wrapping around modulo the line length. Each acknowledged doubleword is written through to the data RAM write port in the cycle it arrives. A valid bit for that doubleword is set at the same clock edge.

The missing load completes one cycle after its own doubleword is acknowledged, while the rest of the line is still arriving. Other loads that target the line under refill can present a lookup. A lookup completes on the cycle after its doubleword is valid. If the doubleword has not arrived yet, the lookup is held until it does and is then answered from the arriving data. A small shadow copy of the line serves lookups to doublewords that are already valid. Only one refill runs at a time. Bus arbitration and tag update are handled elsewhere.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no miss presented, busy_o, mem_req_o, ram_we_o, miss_done_o and lkp_done_o are all low.
- R2: In the cycle after an accepted miss, mem_req_o is high and mem_addr_o equals {miss line, miss index}, with the doubleword index in the low 3 bits.
- R3: The k-th address of a refill (k = 0..7) carries index (critical index + k) mod 8 and the refill's line. Exactly eight addresses are issued per refill, after which mem_req_o stays low.
- R4: While mem_stall_i is high, mem_req_o and mem_addr_o hold their values. The address advances only after a cycle in which mem_stall_i was low.
- R5: In every cycle where mem_ack_i is high during a refill, ram_we_o is high in that same cycle. ram_idx_o is (critical index + n) mod 8 for the n-th acknowledge, and ram_wdata_o equals mem_data_i.
- R6: All per-doubleword valid bits are cleared when a refill starts, so a lookup is not answered from a doubleword of an earlier refill.
- R7: miss_done_o pulses for one cycle, the cycle after the first acknowledge, with miss_data_o equal to that acknowledged data. It does not wait for the rest of the line.
- R8: A lookup to the refilling line whose doubleword is already valid gives lkp_done_o in the next cycle, with lkp_data_o equal to that doubleword.
- R9: A lookup to a doubleword that has not arrived is held. lkp_done_o rises in the cycle after that doubleword's acknowledge, with lkp_data_o equal to the acknowledged data.
- R10: A lookup to a different line, or one made while no refill is running, never produces lkp_done_o.
- R11: busy_o rises the cycle after an accepted miss and falls the cycle after the eighth acknowledge. A miss presented while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Load miss request, accepted when idle |
| miss_line_i | input | LINE_AW | Line address of the miss |
| miss_idx_i | input | IDX_W | Doubleword index wanted by the missing load |
| mem_req_o | output | 1 | Memory read address valid |
| mem_addr_o | output | LINE_AW+IDX_W | Doubleword address {line, index} |
| mem_stall_i | input | 1 | Memory cannot take an address this cycle |
| mem_ack_i | input | 1 | Returned doubleword valid |
| mem_data_i | input | DATA_W | Returned doubleword |
| ram_we_o | output | 1 | Data RAM write enable |
| ram_idx_o | output | IDX_W | Doubleword index being written |
| ram_wdata_o | output | DATA_W | Data RAM write data |
| lkp_valid_i | input | 1 | Load lookup to the in-flight line, held until done |
| lkp_line_i | input | LINE_AW | Line address of the lookup |
| lkp_idx_i | input | IDX_W | Doubleword index of the lookup |
| miss_done_o | output | 1 | Missing load completes |
| miss_data_o | output | DATA_W | Data for the missing load |
| lkp_done_o | output | 1 | Lookup load completes |
| lkp_data_o | output | DATA_W | Data for the lookup load |
| busy_o | output | 1 | Refill in progress |

## Verification
The checker watches a set of local rules on every cycle. The first address must follow the captured miss. The address must hold under stall and step by one modulo the line otherwise. No request or RAM write may occur while idle. A completion must follow a RAM write or a lookup made while busy. Wrap order across a whole line, the exact count of eight addresses, clearing of valid bits between refills, and the exact cycle at which a held lookup is released depend on history across many cycles. Only the bench's sweeps show these, running over every critical index, two memory latencies and with and without stall.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  localparam int unsigned CWF_LINE_DW = 8;
  localparam int unsigned CWF_DATA_W  = 64;
  localparam int unsigned CWF_LINE_AW = 12;

  typedef enum logic {
    RF_IDLE = 1'b0,
    RF_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cwf_issue_seq.sv
// Issues the line's doubleword addresses in wrap order from the critical index.
module cwf_issue_seq #(
  parameter int unsigned LINE_DW = 8,
  localparam int unsigned IDX_W = $clog2(LINE_DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [IDX_W-1:0] crit_i,
  input  logic             stall_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] cnt_q;

  assign req_o = busy_i && (cnt_q != CNT_W'(LINE_DW));
  assign idx_o = crit_i + cnt_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= '0;
    else if (req_o && !stall_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cwf_fill_track.sv
// Refill state, acknowledge count and per-doubleword valid bits.
module cwf_fill_track #(
  parameter int unsigned LINE_DW = 8,
  parameter int unsigned LINE_AW = 12,
  localparam int unsigned IDX_W = $clog2(LINE_DW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [LINE_AW-1:0] miss_line_i,
  input  logic [IDX_W-1:0]   miss_idx_i,
  input  logic               ack_i,
  output logic               start_o,
  output logic               busy_o,
  output logic [LINE_AW-1:0] line_o,
  output logic [IDX_W-1:0]   crit_o,
  output logic               we_o,
  output logic [IDX_W-1:0]   widx_o,
  output logic               first_o,
  output logic [LINE_DW-1:0] vld_o
);
  import cwf_pkg::*;
  localparam int unsigned CNT_W = IDX_W + 1;

  fill_state_e        state_q;
  logic [LINE_AW-1:0] line_q;
  logic [IDX_W-1:0]   crit_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [LINE_DW-1:0] vld_q;
  logic               last;

  assign busy_o  = (state_q == RF_FILL);
  assign start_o = (state_q == RF_IDLE) && miss_valid_i;
  assign we_o    = busy_o && ack_i;
  assign widx_o  = crit_q + cnt_q[IDX_W-1:0];
  assign first_o = we_o && (cnt_q == '0);
  assign last    = (cnt_q == CNT_W'(LINE_DW - 1));
  assign line_o  = line_q;
  assign crit_o  = crit_q;
  assign vld_o   = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      line_q  <= '0;
      crit_q  <= '0;
      cnt_q   <= '0;
      vld_q   <= '0;
    end else if (start_o) begin
      state_q <= RF_FILL;
      line_q  <= miss_line_i;
      crit_q  <= miss_idx_i;
      cnt_q   <= '0;
      vld_q   <= '0;
    end else if (we_o) begin
      vld_q <= vld_q | (LINE_DW'(1) << widx_o);
      cnt_q <= cnt_q + 1'b1;
      if (last) state_q <= RF_IDLE;
    end
  end
endmodule

// File: rtl/cwf_line_buf.sv
// Shadow copy of the refilling line and load completion for miss and lookups.
module cwf_line_buf #(
  parameter int unsigned LINE_DW = 8,
  parameter int unsigned LINE_AW = 12,
  parameter int unsigned DATA_W  = 64,
  localparam int unsigned IDX_W = $clog2(LINE_DW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic [LINE_AW-1:0] line_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   widx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               first_i,
  input  logic [LINE_DW-1:0] vld_i,
  input  logic               lkp_valid_i,
  input  logic [LINE_AW-1:0] lkp_line_i,
  input  logic [IDX_W-1:0]   lkp_idx_i,
  output logic               miss_done_o,
  output logic [DATA_W-1:0]  miss_data_o,
  output logic               lkp_done_o,
  output logic [DATA_W-1:0]  lkp_data_o
);
  logic [DATA_W-1:0] dw_q [LINE_DW];
  logic hit_valid, hit_arr, lkp_hit;

  for (genvar g = 0; g < LINE_DW; g++) begin : g_dw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            dw_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))   dw_q[g] <= wdata_i;
    end
  end

  assign hit_valid = vld_i[lkp_idx_i];
  assign hit_arr   = we_i && (widx_i == lkp_idx_i);
  assign lkp_hit   = lkp_valid_i && busy_i && (lkp_line_i == line_i) && (hit_valid || hit_arr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_done_o <= 1'b0;
      miss_data_o <= '0;
      lkp_done_o  <= 1'b0;
      lkp_data_o  <= '0;
    end else begin
      miss_done_o <= first_i;
      if (first_i) miss_data_o <= wdata_i;
      lkp_done_o <= lkp_hit;
      if (lkp_hit) lkp_data_o <= hit_valid ? dw_q[lkp_idx_i] : wdata_i;
    end
  end
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
  parameter int unsigned LINE_DW = cwf_pkg::CWF_LINE_DW,
  parameter int unsigned DATA_W  = cwf_pkg::CWF_DATA_W,
  parameter int unsigned LINE_AW = cwf_pkg::CWF_LINE_AW,
  localparam int unsigned IDX_W = $clog2(LINE_DW)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     miss_valid_i,
  input  logic [LINE_AW-1:0]       miss_line_i,
  input  logic [IDX_W-1:0]         miss_idx_i,
  output logic                     mem_req_o,
  output logic [LINE_AW+IDX_W-1:0] mem_addr_o,
  input  logic                     mem_stall_i,
  input  logic                     mem_ack_i,
  input  logic [DATA_W-1:0]        mem_data_i,
  output logic                     ram_we_o,
  output logic [IDX_W-1:0]         ram_idx_o,
  output logic [DATA_W-1:0]        ram_wdata_o,
  input  logic                     lkp_valid_i,
  input  logic [LINE_AW-1:0]       lkp_line_i,
  input  logic [IDX_W-1:0]         lkp_idx_i,
  output logic                     miss_done_o,
  output logic [DATA_W-1:0]        miss_data_o,
  output logic                     lkp_done_o,
  output logic [DATA_W-1:0]        lkp_data_o,
  output logic                     busy_o
);
  logic               start, busy, we, first;
  logic [LINE_AW-1:0] line;
  logic [IDX_W-1:0]   crit, widx, iss_idx;
  logic [LINE_DW-1:0] vld;

  cwf_fill_track #(.LINE_DW(LINE_DW), .LINE_AW(LINE_AW)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .miss_line_i  (miss_line_i),
    .miss_idx_i   (miss_idx_i),
    .ack_i        (mem_ack_i),
    .start_o      (start),
    .busy_o       (busy),
    .line_o       (line),
    .crit_o       (crit),
    .we_o         (we),
    .widx_o       (widx),
    .first_o      (first),
    .vld_o        (vld)
  );

  cwf_issue_seq #(.LINE_DW(LINE_DW)) u_issue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_i  (busy),
    .crit_i  (crit),
    .stall_i (mem_stall_i),
    .req_o   (mem_req_o),
    .idx_o   (iss_idx)
  );

  cwf_line_buf #(.LINE_DW(LINE_DW), .LINE_AW(LINE_AW), .DATA_W(DATA_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .line_i      (line),
    .we_i        (we),
    .widx_i      (widx),
    .wdata_i     (mem_data_i),
    .first_i     (first),
    .vld_i       (vld),
    .lkp_valid_i (lkp_valid_i),
    .lkp_line_i  (lkp_line_i),
    .lkp_idx_i   (lkp_idx_i),
    .miss_done_o (miss_done_o),
    .miss_data_o (miss_data_o),
    .lkp_done_o  (lkp_done_o),
    .lkp_data_o  (lkp_data_o)
  );

  assign mem_addr_o  = {line, iss_idx};
  assign ram_we_o    = we;
  assign ram_idx_o   = widx;
  assign ram_wdata_o = mem_data_i;
  assign busy_o      = busy;
endmodule

// File: rtl/cwf_refill_sva.sv
module cwf_refill_sva #(
  parameter int unsigned LINE_AW = 12,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned DATA_W  = 64
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     miss_valid_i,
  input logic [LINE_AW-1:0]       miss_line_i,
  input logic [IDX_W-1:0]         miss_idx_i,
  input logic                     mem_req_o,
  input logic [LINE_AW+IDX_W-1:0] mem_addr_o,
  input logic                     mem_stall_i,
  input logic                     ram_we_o,
  input logic [DATA_W-1:0]        ram_wdata_o,
  input logic                     lkp_valid_i,
  input logic                     miss_done_o,
  input logic [DATA_W-1:0]        miss_data_o,
  input logic                     lkp_done_o,
  input logic                     busy_o
);
  p_start_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_req_o && (mem_addr_o == {$past(miss_line_i), $past(miss_idx_i)}));

  p_wrap_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_stall_i) |=>
      (!mem_req_o || (mem_addr_o[IDX_W-1:0] == IDX_W'($past(mem_addr_o[IDX_W-1:0]) + 1'b1))));

  p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_stall_i) |=> mem_req_o && $stable(mem_addr_o));

  p_miss_done_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_done_o |-> $past(ram_we_o) && (miss_data_o == $past(ram_wdata_o)));

  p_lkp_done_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_done_o |-> $past(lkp_valid_i) && $past(busy_o));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !ram_we_o);

  p_busy_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(miss_valid_i));
endmodule

bind cwf_refill_ctrl cwf_refill_sva #(
  .LINE_AW (LINE_AW),
  .IDX_W   (IDX_W),
  .DATA_W  (DATA_W)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .miss_valid_i (miss_valid_i),
  .miss_line_i  (miss_line_i),
  .miss_idx_i   (miss_idx_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_stall_i  (mem_stall_i),
  .ram_we_o     (ram_we_o),
  .ram_wdata_o  (ram_wdata_o),
  .lkp_valid_i  (lkp_valid_i),
  .miss_done_o  (miss_done_o),
  .miss_data_o  (miss_data_o),
  .lkp_done_o   (lkp_done_o),
  .busy_o       (busy_o)
);

// File: tb/cwf_refill_ctrl_tb_top.sv
module cwf_refill_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic [11:0] miss_line;
  logic [2:0]  miss_idx;
  logic        mem_req_o;
  logic [14:0] mem_addr_o;
  logic        mem_stall;
  logic        mem_ack;
  logic [63:0] mem_data;
  logic        ram_we_o;
  logic [2:0]  ram_idx_o;
  logic [63:0] ram_wdata_o;
  logic        lkp_valid;
  logic [11:0] lkp_line;
  logic [2:0]  lkp_idx;
  logic        miss_done_o;
  logic [63:0] miss_data_o;
  logic        lkp_done_o;
  logic [63:0] lkp_data_o;
  logic        busy_o;

  int n_chk = 0;
  int n_err = 0;

  cwf_refill_ctrl dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .miss_valid_i (miss_valid),
    .miss_line_i  (miss_line),
    .miss_idx_i   (miss_idx),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_stall_i  (mem_stall),
    .mem_ack_i    (mem_ack),
    .mem_data_i   (mem_data),
    .ram_we_o     (ram_we_o),
    .ram_idx_o    (ram_idx_o),
    .ram_wdata_o  (ram_wdata_o),
    .lkp_valid_i  (lkp_valid),
    .lkp_line_i   (lkp_line),
    .lkp_idx_i    (lkp_idx),
    .miss_done_o  (miss_done_o),
    .miss_data_o  (miss_data_o),
    .lkp_done_o   (lkp_done_o),
    .lkp_data_o   (lkp_data_o),
    .busy_o       (busy_o)
  );

  initial forever #5 clk = ~clk;

  function automatic logic [63:0] pat(input logic [11:0] ln, input int ix);
    return 64'h0123_4567_89AB_CDEF ^ ({52'd0, ln} << 20) ^ (64'(ix & 7) * 64'h0101_0101_0101_0101);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(!busy_o, {req, " busy"}, 64'(busy_o), 64'd0);
    chk(!mem_req_o, {req, " mem_req"}, 64'(mem_req_o), 64'd0);
    chk(!ram_we_o, {req, " ram_we"}, 64'(ram_we_o), 64'd0);
    chk(!miss_done_o, {req, " miss_done"}, 64'(miss_done_o), 64'd0);
    chk(!lkp_done_o, {req, " lkp_done"}, 64'(lkp_done_o), 64'd0);
  endtask

  task automatic do_refill(input int it, input int crit, input int mode);
    logic [11:0] line;
    int lat, t1, head, tail, n_iss, n_ack, prev_idx, prev_ord, this_idx, this_ord, lk, k;
    bit stl, wrong, exp_busy, exp_l, exp_req;
    logic [63:0] d, exp_d;
    string tag;
    int qi[16];
    int qr[16];
    line = 12'(it * 37 + 5);
    lat = ((mode & 1) != 0) ? 3 : 1;
    stl = (mode & 2) != 0;
    wrong = (crit % 2) == 1;
    t1 = (crit + 5) % 8;
    head = 0; tail = 0; n_iss = 0; n_ack = 0;
    prev_idx = -1; prev_ord = -1; lk = 0; k = 0;
    exp_busy = 1'b1;
    d = '0; exp_d = '0;

    @(negedge clk);
    miss_valid = 1'b1; miss_line = line; miss_idx = 3'(crit); lkp_valid = 1'b0;
    while (1) begin
      @(negedge clk);
      miss_valid = 1'b0;
      chk(busy_o == exp_busy, "R11 busy", 64'(busy_o), 64'(exp_busy));
      chk(miss_done_o == (prev_ord == 0), "R7 miss done timing", 64'(miss_done_o), 64'(prev_ord == 0));
      if (miss_done_o && prev_ord == 0)
        chk(miss_data_o == pat(line, crit), "R7 miss data", miss_data_o, pat(line, crit));
      exp_l = 1'b0; tag = "R10 foreign line lookup";
      if (!wrong) begin
        if (lk == 0) begin
          exp_l = (prev_idx == t1); exp_d = pat(line, t1); tag = "R9 held lookup (R6 cleared valid)";
        end else if (lk == 1) begin
          exp_l = 1'b1; exp_d = pat(line, crit); tag = "R8 valid lookup";
        end else tag = "R8 no lookup";
      end
      chk(lkp_done_o == exp_l, tag, 64'(lkp_done_o), 64'(exp_l));
      if (exp_l && lkp_done_o) chk(lkp_data_o == exp_d, {tag, " data"}, lkp_data_o, exp_d);
      if (exp_l) lk++;
      if (!exp_busy) break;

      exp_req = n_iss < 8;
      chk(mem_req_o == exp_req, "R3 request count", 64'(mem_req_o), 64'(exp_req));
      if (mem_req_o && exp_req)
        chk(mem_addr_o == {line, 3'(crit + n_iss)},
            (n_iss == 0) ? "R2 first address" : "R3 wrap address (R4 stall, R11 ignored miss)",
            64'(mem_addr_o), 64'({line, 3'(crit + n_iss)}));

      mem_stall = stl && (k % 2 == 1);
      if (head < tail && qr[head] <= k) begin
        d = pat(line, qi[head]);
        mem_ack = 1'b1; mem_data = d;
        this_idx = qi[head]; this_ord = n_ack;
        head++; n_ack++;
      end else begin
        mem_ack = 1'b0; mem_data = 64'hDEAD_BEEF_0000_0000 | 64'(k);
        this_idx = -1; this_ord = -1;
      end
      if (wrong) begin
        lkp_valid = 1'b1; lkp_line = line ^ 12'h001; lkp_idx = 3'(crit);
      end else begin
        lkp_line = line;
        lkp_valid = (lk < 2);
        lkp_idx = (lk == 0) ? 3'(t1) : 3'(crit);
      end
      if (k == 3) begin
        miss_valid = 1'b1; miss_line = line + 12'd2; miss_idx = 3'(crit + 1);
      end
      #1;
      chk(ram_we_o == mem_ack, "R5 write strobe", 64'(ram_we_o), 64'(mem_ack));
      if (mem_ack && ram_we_o) begin
        chk(ram_idx_o == 3'(this_idx), "R5 write index", 64'(ram_idx_o), 64'(this_idx));
        chk(ram_wdata_o == d, "R5 write data", ram_wdata_o, d);
      end
      if (mem_req_o && !mem_stall) begin
        qi[tail] = (crit + n_iss) % 8; qr[tail] = k + lat;
        tail++; n_iss++;
      end
      exp_busy = n_ack < 8;
      prev_idx = this_idx; prev_ord = this_ord;
      k++;
      if (k > 200) break;
    end
    chk(!mem_req_o, "R3 exactly eight addresses", 64'(mem_req_o), 64'd0);
    mem_ack = 1'b0; mem_stall = 1'b0;
    lkp_valid = 1'b1; lkp_line = line; lkp_idx = 3'(crit);
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      chk(!lkp_done_o, "R10 idle lookup", 64'(lkp_done_o), 64'd0);
    end
    lkp_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    miss_valid = 1'b0; miss_line = '0; miss_idx = '0;
    mem_stall = 1'b0; mem_ack = 1'b0; mem_data = '0;
    lkp_valid = 1'b0; lkp_line = '0; lkp_idx = '0;
    repeat (3) @(negedge clk);
    chk_quiet("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_quiet("R1 after reset");
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 8; c++)
        do_refill(m * 8 + c, c, m);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R11 watchdog actual=hung expected=refills complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule